// File: doc/BRIEF.md
# Windowed Register File with Shared Overlap

This block is a processor register file with 32 logical register numbers. Behind those numbers sits a larger physical array. A procedure sees only one window of that array at a time, and a current-window pointer picks the window. The windows form a ring. A call moves the pointer one step forward and a return moves it one step back. The incoming group of a window is the same storage as the outgoing group of the window before it, so arguments and results pass between caller and callee without any copying. A bank of global registers stays visible from every window.

The file has two combinational read ports and one write port that acts on the clock edge. All three ports take logical register numbers.

The block keeps count of how many windows are resident. It raises a trap when a call would reuse a window that is still live, and another trap when a return finds no caller window left. Saving windows to memory and restoring them is left to trap handlers outside the block.

Top module: `regwin_file`

## Requirements
- R1: After reset, the pointer is at window 0 and one window is resident. Every register reads zero and both trap outputs are low.
- R2: Logical register 0 always reads zero, and a write to it has no effect.
- R3: Logical registers 1 to 7 are globals. They hold the same contents whichever window is current.
- R4: A completed call makes logical registers 24 to 31 of the new window read what the caller held in logical registers 8 to 15, offset for offset. After a return, the caller's 8 to 15 show what the callee wrote into its 24 to 31.
- R5: Logical registers 16 to 23 are local to each window. A write there is not visible from any other window.
- R6: A call made while all eight windows are resident raises the overflow trap for exactly one cycle, after the next clock edge. The pointer and the register mapping stay unchanged.
- R7: A return made while only one window is resident raises the underflow trap for exactly one cycle, after the next clock edge. The pointer stays unchanged.
- R8: A read of a register in the same cycle as a write to it returns the old value. A write that coincides with a call or return is made through the window that was current before the edge. A call or return changes the mapping only from the clock edge after the strobe.
- R9: A call and a return strobed in the same cycle have no effect and raise no trap.
- R10: The ring wraps around. The incoming group of window 0 is the outgoing group of window 7. A value written to register 24 at window 0 therefore reads back from register 8 after seven calls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 5 | Logical register number for read port A |
| rd_a_data | output | 32 | Read port A data (combinational) |
| rd_b_idx | input | 5 | Logical register number for read port B |
| rd_b_data | output | 32 | Read port B data (combinational) |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Logical register number to write |
| wr_data | input | 32 | Write data |
| call_i | input | 1 | Procedure call strobe |
| ret_i | input | 1 | Procedure return strobe |
| ovf_trap | output | 1 | Window overflow trap, one-cycle pulse |
| unf_trap | output | 1 | Window underflow trap, one-cycle pulse |

## Verification
A seeded random mix of calls, returns, writes and dual reads is run against a bench model of the window mapping. It drives the pointer through the whole range of resident counts and covers reads that collide with writes. This tells a correct overlap apart from an off-by-one window offset or a swapped in/out group.

Directed sequences cover the following cases:
- a chain of nested calls, to separate the private local groups from the shared globals;
- eight resident windows followed by a call, and one resident window followed by a return, to check that the traps leave the pointer where it was;
- simultaneous call and return strobes;
- the seven-call walk that shows window 0 and window 7 sharing a group across the ring boundary.

// File: rtl/regwin_file.sv
module regwin_file #(
  parameter int DW   = 32,
  parameter int NWIN = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [4:0]    rd_a_idx,
  output logic [DW-1:0] rd_a_data,
  input  logic [4:0]    rd_b_idx,
  output logic [DW-1:0] rd_b_data,
  input  logic          wr_en,
  input  logic [4:0]    wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          call_i,
  input  logic          ret_i,
  output logic          ovf_trap,
  output logic          unf_trap
);
  localparam int GRP   = 8;
  localparam int NPHYS = GRP + NWIN * 2 * GRP;
  localparam int PW    = $clog2(NPHYS);
  localparam int WW    = $clog2(NWIN);
  localparam int CW    = $clog2(NWIN + 1);

  logic [DW-1:0] rf [NPHYS];
  logic [WW-1:0] cwp;
  logic [CW-1:0] resident;

  function automatic logic [PW-1:0] map_reg(input logic [WW-1:0] w, input logic [4:0] r);
    int base_cur, base_prev, off;
    logic [WW-1:0] wp;
    wp        = w - 1'b1;
    base_cur  = GRP + int'(w) * 2 * GRP;
    base_prev = GRP + int'(wp) * 2 * GRP;
    off       = int'(r[2:0]);
    case (r[4:3])
      2'd0:    return PW'(off);
      2'd1:    return PW'(base_cur + off);
      2'd2:    return PW'(base_cur + GRP + off);
      default: return PW'(base_prev + off);
    endcase
  endfunction

  wire [PW-1:0] pa = map_reg(cwp, rd_a_idx);
  wire [PW-1:0] pb = map_reg(cwp, rd_b_idx);
  wire [PW-1:0] pw = map_reg(cwp, wr_idx);

  assign rd_a_data = (rd_a_idx == 5'd0) ? '0 : rf[pa];
  assign rd_b_data = (rd_b_idx == 5'd0) ? '0 : rf[pb];

  wire do_call  = call_i & ~ret_i;
  wire do_ret   = ret_i & ~call_i;
  wire full     = (resident == CW'(NWIN));
  wire only_one = (resident == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPHYS; i++) rf[i] <= '0;
    end else if (wr_en && wr_idx != 5'd0) begin
      rf[pw] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cwp      <= '0;
      resident <= CW'(1);
      ovf_trap <= 1'b0;
      unf_trap <= 1'b0;
    end else begin
      ovf_trap <= do_call & full;
      unf_trap <= do_ret & only_one;
      if (do_call && !full) begin
        cwp      <= cwp + 1'b1;
        resident <= resident + 1'b1;
      end else if (do_ret && !only_one) begin
        cwp      <= cwp - 1'b1;
        resident <= resident - 1'b1;
      end
    end
  end
endmodule

// File: rtl/regwin_file_chk.sv
module regwin_file_chk #(
  parameter int NWIN = 8,
  parameter int WW   = $clog2(NWIN),
  parameter int CW   = $clog2(NWIN + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          call_i,
  input logic          ret_i,
  input logic          ovf_trap,
  input logic          unf_trap,
  input logic [4:0]    rd_a_idx,
  input logic [31:0]   rd_a_data,
  input logic [WW-1:0] cwp,
  input logic [CW-1:0] resident
);
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && !ret_i && resident == CW'(NWIN)) |=> (ovf_trap && $stable(cwp)));

  p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !call_i && resident == CW'(1)) |=> (unf_trap && $stable(cwp)));

  p_call_advances_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && !ret_i && resident != CW'(NWIN)) |=> (cwp == $past(cwp) + 1'b1));

  p_both_strobes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && ret_i) |=> ($stable(cwp) && !ovf_trap && !unf_trap));

  p_zero_reg_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == 5'd0) |-> (rd_a_data == '0));

  p_resident_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (resident >= CW'(1)) && (resident <= CW'(NWIN)));
endmodule

bind regwin_file regwin_file_chk #(.NWIN(NWIN)) chk_i (
  .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
  .ovf_trap(ovf_trap), .unf_trap(unf_trap),
  .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
  .cwp(cwp), .resident(resident)
);

// File: tb/regwin_file_tb_top.sv
module regwin_file_tb_top;
  localparam int NWIN  = 8;
  localparam int NPHYS = 8 + NWIN * 16;

  logic clk = 0, rst_n = 0;
  logic [4:0] ra = 0, rb = 0, widx = 0;
  logic [31:0] rda, rdb, wdat = 0;
  logic we = 0, call = 0, ret = 0;
  logic ovf, unf;

  always #10 clk = ~clk;

  regwin_file dut_i (
    .clk(clk), .rst_n(rst_n), .rd_a_idx(ra), .rd_a_data(rda),
    .rd_b_idx(rb), .rd_b_data(rdb), .wr_en(we), .wr_idx(widx),
    .wr_data(wdat), .call_i(call), .ret_i(ret), .ovf_trap(ovf), .unf_trap(unf)
  );

  int errors = 0, checks = 0;
  logic [31:0] mdl [NPHYS];
  int mcwp, mres;
  bit done = 0;

  function automatic int phys(int w, logic [4:0] r);
    int o = int'(r[2:0]);
    case (r[4:3])
      2'd0:    return o;
      2'd1:    return 8 + w * 16 + o;
      2'd2:    return 16 + w * 16 + o;
      default: return 8 + ((w + NWIN - 1) % NWIN) * 16 + o;
    endcase
  endfunction

  function automatic logic [31:0] expect_rd(logic [4:0] r);
    return (r == 0) ? 32'd0 : mdl[phys(mcwp, r)];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; we = 0; call = 0; ret = 0;
    @(posedge clk); #2;
    @(negedge clk); rst_n = 1;
    for (int i = 0; i < NPHYS; i++) mdl[i] = 0;
    mcwp = 0; mres = 1;
  endtask

  // one cycle: drive, check reads before edge, update model, check traps after edge
  task automatic cyc(string req, bit c, bit r, bit w, logic [4:0] wi, logic [31:0] wd,
                     logic [4:0] a, logic [4:0] b);
    bit eo, eu;
    @(negedge clk);
    call = c; ret = r; we = w; widx = wi; wdat = wd; ra = a; rb = b;
    #2;
    chk(req, rda, expect_rd(a));
    chk(req, rdb, expect_rd(b));
    eo = c && !r && mres == NWIN;
    eu = r && !c && mres == 1;
    @(posedge clk);
    if (w && wi != 0) mdl[phys(mcwp, wi)] = wd;
    if (c && !r && !eo) begin mcwp = (mcwp + 1) % NWIN; mres++; end
    else if (r && !c && !eu) begin mcwp = (mcwp + NWIN - 1) % NWIN; mres--; end
    #2;
    chk(req, {31'd0, ovf}, {31'd0, eo});
    chk(req, {31'd0, unf}, {31'd0, eu});
  endtask

  task automatic idle_rd(string req, logic [4:0] a, logic [31:0] exp);
    cyc(req, 0, 0, 0, 0, 0, a, a);
    chk(req, rda, exp);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    do_reset();
    // R1 reset state
    chk("R1", {31'd0, ovf}, 0);
    chk("R1", {31'd0, unf}, 0);
    for (int i = 0; i < 32; i++) cyc("R1", 0, 0, 0, 0, 0, 5'(i), 5'(31 - i));
    // R2 r0 ignores writes
    cyc("R2", 0, 0, 1, 0, 32'hdeadbeef, 0, 0);
    idle_rd("R2", 0, 0);
    // R3 globals, R5 locals, R4 overlap
    cyc("R3", 0, 0, 1, 5, 32'h11110005, 0, 0);
    cyc("R5", 0, 0, 1, 18, 32'h22220018, 0, 0);
    cyc("R4", 0, 0, 1, 11, 32'h3333000b, 0, 0);
    cyc("R4", 1, 0, 0, 0, 0, 0, 0);
    idle_rd("R4", 27, 32'h3333000b);
    idle_rd("R3", 5, 32'h11110005);
    idle_rd("R5", 18, 0);
    cyc("R4", 0, 0, 1, 29, 32'h4444001d, 0, 0);
    cyc("R4", 0, 1, 0, 0, 0, 0, 0);
    idle_rd("R4", 13, 32'h4444001d);
    idle_rd("R5", 18, 32'h22220018);
    // R8 same-cycle read of written reg, write with call uses old window
    cyc("R8", 0, 0, 1, 9, 32'h55550009, 9, 9);
    idle_rd("R8", 9, 32'h55550009);
    cyc("R8", 1, 0, 1, 20, 32'h66660014, 20, 20);
    idle_rd("R8", 20, 0);
    cyc("R8", 0, 1, 0, 0, 0, 20, 20);
    idle_rd("R8", 20, 32'h66660014);
    // R7 underflow
    cyc("R7", 0, 1, 0, 0, 0, 0, 0);
    idle_rd("R7", 20, 32'h66660014);
    // R9 simultaneous strobes
    cyc("R9", 1, 1, 0, 0, 0, 0, 0);
    idle_rd("R9", 9, 32'h55550009);
    // R10 wrap, R6 overflow
    cyc("R10", 0, 0, 1, 24, 32'h77770018, 0, 0);
    for (int i = 0; i < 7; i++) cyc("R10", 1, 0, 0, 0, 0, 8, 24);
    idle_rd("R10", 8, 32'h77770018);
    cyc("R6", 1, 0, 0, 0, 0, 0, 0);
    idle_rd("R6", 8, 32'h77770018);
    // random mix
    do_reset();
    for (int n = 0; n < 4000; n++) begin
      int k = $urandom_range(0, 99);
      bit c = k < 20, r = k >= 20 && k < 38;
      if (k >= 97) begin c = 1; r = 1; end
      cyc("R4", c, r, $urandom_range(0, 1) == 1, 5'($urandom), $urandom,
          5'($urandom), 5'($urandom));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule